// File: doc/BRIEF.md
# Mode-2 Interrupt Vector Controller

This block gathers interrupt requests from three DMA channels and one raster source and presents them to a Z80-style CPU as a single active-low interrupt line. When the CPU acknowledges the interrupt (M1 and IORQ both low), the block selects the highest-priority pending source. It places an 8-bit vector on the data bus, which the CPU combines with its own page register to fetch a handler address from an even table slot.

The vector is built in three parts. The upper nibble comes from a software-written base register. Bits 3..1 carry a source code chosen by hardware. Bit 0 is always zero. The raster source is the OR of two requests. The first is a periodic request from a scanline counter that fires every 52 horizontal syncs. The second is a line-match request that fires when the current scanline equals a programmable line register. A small synchronous write port holds the base register and the line register, and a combinational read port returns their contents.

Top module: `irqv_top`

## Requirements
- R1: The vector is driven (vec_oe=1) only while m1_n and iorq_n are both low, starting the cycle after both fall. It holds the value captured at that first edge for the whole acknowledge.
- R2: Bit 0 of the vector is always 0, and bits 7..4 equal bits 7..4 of the base register at offset 5.
- R3: Vector bits 3..1 are 000 for DMA0, 001 for DMA1, 011 for DMA2, 100 for raster, and 111 when nothing is pending at the acknowledge.
- R4: Priority among pending requests is raster, then DMA2, then DMA1, then DMA0.
- R5: Each acknowledge clears only the pending flag of the source it reports.
- R6: int_n is low in the cycle after any request strobe and stays low until every pending flag has been cleared.
- R7: The scanline counter advances on each hsync_stb and raises a raster request on the 52nd strobe since it was last cleared. It is cleared by that request and by vsync_stb.
- R8: When hsync_stb is high, a raster request is raised if line_num equals the line register at offset 0. A line register value of 0 disables this match.
- R9: After reset, offset 5 reads 8'h01 and offset 0 reads 8'h00. Writes to offsets other than 0 and 5 change no register.
- R10: A request strobe that arrives in the same cycle as the acknowledge that clears its own source leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 3 | One-cycle request strobes from DMA channels 0..2 |
| hsync_stb | input | 1 | One-cycle horizontal-sync strobe |
| vsync_stb | input | 1 | One-cycle vertical-sync strobe |
| line_num | input | 8 | Current scanline number |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| m1_n | input | 1 | CPU M1, active low |
| iorq_n | input | 1 | CPU IORQ, active low |
| int_n | output | 1 | Interrupt request to the CPU, active low |
| vec_oe | output | 1 | Vector drive enable on the data bus |
| vec_data | output | 8 | Vector value, zero when not driven |

## Verification
A request strobe applied before a clock edge shows up on int_n right after that edge, so the bench drives strobes on the falling edge and samples int_n on the next falling edge. The vector is captured at the first edge where both acknowledge lines are low and appears on vec_data from then on. The bench therefore checks it one falling edge after lowering m1_n and iorq_n, and checks that int_n has returned high one falling edge after the acknowledge is released. Register reads are combinational and are sampled a short delay after the address changes. The sweeps cover every base nibble against every source, every combination of simultaneous requests against the priority order, and the 52-strobe period with and without an intervening vsync.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int NSRC     = 4;
    localparam int CODE_W   = 3;
    localparam int SRC_DMA0 = 0;
    localparam int SRC_DMA1 = 1;
    localparam int SRC_DMA2 = 2;
    localparam int SRC_RAST = 3;
    localparam logic [CODE_W-1:0] CODE_NONE = 3'b111;

    function automatic logic [CODE_W-1:0] code_of(input int idx);
        case (idx)
            SRC_DMA0: code_of = 3'b000;
            SRC_DMA1: code_of = 3'b001;
            SRC_DMA2: code_of = 3'b011;
            SRC_RAST: code_of = 3'b100;
            default:  code_of = CODE_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int BASE_OFS = 5,
    parameter int LINE_OFS = 0,
    parameter logic [DATA_W-1:0] BASE_RST = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] base_reg,
    output logic [DATA_W-1:0] line_reg
);
    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] line;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we && addr == ADDR_W'(BASE_OFS)) r_d.base = wdata;
        if (we && addr == ADDR_W'(LINE_OFS)) r_d.line = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.base <= BASE_RST;
            r_q.line <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (addr == ADDR_W'(BASE_OFS))      rdata = r_q.base;
        else if (addr == ADDR_W'(LINE_OFS)) rdata = r_q.line;
        else                                rdata = '0;
    end

    assign base_reg = r_q.base;
    assign line_reg = r_q.line;

    // R9: a write to any other offset leaves both registers unchanged
    p_other_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr != ADDR_W'(BASE_OFS) && addr != ADDR_W'(LINE_OFS))
        |=> (base_reg == $past(base_reg) && line_reg == $past(line_reg)));

    // R9: a base write lands in the register one edge later
    p_base_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(BASE_OFS)) |=> base_reg == $past(wdata));
endmodule

// File: rtl/irqv_raster.sv
module irqv_raster #(
    parameter int LINE_W = 8,
    parameter int PERIOD = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_stb,
    input  logic              vsync_stb,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] line_sel,
    output logic              hit
);
    localparam int CNT_W = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rast_t;

    rast_t s_d, s_q;
    logic  period_hit;
    logic  line_hit;

    always_comb begin
        s_d        = s_q;
        period_hit = 1'b0;
        if (vsync_stb) begin
            s_d.cnt = '0;
        end else if (hsync_stb) begin
            if (s_q.cnt == CNT_W'(PERIOD - 1)) begin
                s_d.cnt    = '0;
                period_hit = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        line_hit = hsync_stb && (line_sel != '0) && (line_num == line_sel);
        hit      = period_hit || line_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: the count never reaches the period value
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CNT_W'(PERIOD));

    // R7: a vsync strobe returns the count to zero
    p_vsync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_stb |=> s_q.cnt == '0);

    // R8: no hit without a horizontal strobe
    p_hit_needs_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> hsync_stb);
endmodule

// File: rtl/irqv_arb.sv
module irqv_arb
    import irqv_pkg::*;
#(
    parameter int BASE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   set_req,
    input  logic              ack,
    input  logic [BASE_W-1:0] base,
    output logic              int_n,
    output logic              vec_oe,
    output logic [BASE_W+CODE_W:0] vec_data
);
    localparam int VEC_W = BASE_W + CODE_W + 1;

    typedef struct packed {
        logic [NSRC-1:0]  pend;
        logic             ack;
        logic [VEC_W-1:0] vec;
    } arb_t;

    arb_t              s_d, s_q;
    logic              ack_rise;
    logic              found;
    logic [NSRC-1:0]   clr;
    logic [CODE_W-1:0] win_code;

    always_comb begin
        found    = 1'b0;
        clr      = '0;
        win_code = CODE_NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (s_q.pend[i]) begin
                found    = 1'b1;
                clr      = '0;
                clr[i]   = 1'b1;
                win_code = code_of(i);
            end
        end

        ack_rise = ack && !s_q.ack;
        s_d      = s_q;
        s_d.ack  = ack;
        if (ack_rise) begin
            s_d.vec  = {base, win_code, 1'b0};
            s_d.pend = (s_q.pend & ~clr) | set_req;
        end else begin
            s_d.pend = s_q.pend | set_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign int_n    = ~|s_q.pend;
    assign vec_oe   = ack && s_q.ack;
    assign vec_data = vec_oe ? s_q.vec : '0;

    // R1: the vector holds steady across a continuing acknowledge
    p_vec_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && $past(vec_oe)) |-> $stable(vec_data));

    // R5: an acknowledge without new requests removes exactly one flag
    p_single_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && set_req == '0 && s_q.pend != '0)
        |=> ($countones(s_q.pend) + 1 == $countones($past(s_q.pend))));

    // R10: an incoming request is always pending on the next edge
    p_no_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req != '0) |=> ((s_q.pend & $past(set_req)) == $past(set_req)));

    // R3: captured code is one of the defined values
    p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (vec_data[CODE_W:1] inside {3'b000, 3'b001, 3'b011, 3'b100, 3'b111}));
endmodule

// File: rtl/irqv_top.sv
module irqv_top
    import irqv_pkg::*;
#(
    parameter int LINE_W = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int PERIOD = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        dma_req,
    input  logic              hsync_stb,
    input  logic              vsync_stb,
    input  logic [LINE_W-1:0] line_num,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              m1_n,
    input  logic              iorq_n,
    output logic              int_n,
    output logic              vec_oe,
    output logic [DATA_W-1:0] vec_data
);
    localparam int BASE_W = DATA_W - CODE_W - 1;

    logic [DATA_W-1:0] base_reg;
    logic [DATA_W-1:0] line_reg;
    logic              rast_hit;
    logic [NSRC-1:0]   set_req;
    logic              ack;

    assign ack     = !m1_n && !iorq_n;
    assign set_req = {rast_hit, dma_req};

    irqv_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_OFS(5), .LINE_OFS(0),
        .BASE_RST(DATA_W'(1))
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .base_reg(base_reg), .line_reg(line_reg)
    );

    irqv_raster #(.LINE_W(LINE_W), .PERIOD(PERIOD)) u_raster (
        .clk(clk), .rst_n(rst_n), .hsync_stb(hsync_stb), .vsync_stb(vsync_stb),
        .line_num(line_num), .line_sel(line_reg[LINE_W-1:0]), .hit(rast_hit)
    );

    irqv_arb #(.BASE_W(BASE_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .ack(ack),
        .base(base_reg[DATA_W-1 -: BASE_W]),
        .int_n(int_n), .vec_oe(vec_oe), .vec_data(vec_data)
    );

    // R1: the vector is only driven inside an acknowledge
    p_oe_in_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (!m1_n && !iorq_n));

    // R2: emitted vector bit 0 is clear
    p_even_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> !vec_data[0]);
endmodule

// File: tb/irqv_top_test.sv
module irqv_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dma_req = '0;
    logic       hsync_stb = 1'b0;
    logic       vsync_stb = 1'b0;
    logic [7:0] line_num = 8'd200;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       m1_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic       int_n;
    logic       vec_oe;
    logic [7:0] vec_data;

    int n_chk = 0;
    int n_bad = 0;

    irqv_top uut (
        .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .hsync_stb(hsync_stb),
        .vsync_stb(vsync_stb), .line_num(line_num), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .m1_n(m1_n), .iorq_n(iorq_n), .int_n(int_n), .vec_oe(vec_oe),
        .vec_data(vec_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [2:0] code_exp(input int k);
        case (k)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b011;
            3: return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic vs();
        vsync_stb = 1'b1; tick(); vsync_stb = 1'b0;
    endtask

    task automatic hs(input logic [7:0] ln);
        hsync_stb = 1'b1; line_num = ln; tick();
        hsync_stb = 1'b0; line_num = 8'd200;
    endtask

    // drive a request mask: bits 2..0 DMA, bit 3 raster via line match on line ln
    task automatic fire(input logic [3:0] m, input logic [7:0] ln);
        dma_req = m[2:0]; hsync_stb = m[3]; line_num = ln;
        tick();
        dma_req = '0; hsync_stb = 1'b0; line_num = 8'd200;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic oe);
        m1_n = 1'b0; iorq_n = 1'b0;
        tick();
        v = vec_data; oe = vec_oe;
        m1_n = 1'b1; iorq_n = 1'b1;
        tick();
    endtask

    logic [7:0] v, r;
    logic       oe;

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R9 reset values, R6 idle line, R1 no drive
        rd(4'd5, r); check("R9 base reset", 16'(r), 16'h01);
        rd(4'd0, r); check("R9 line reset", 16'(r), 16'h00);
        check("R6 int idle", 16'(int_n), 16'h1);
        check("R1 no drive idle", 16'(vec_oe), 16'h0);

        // R9 unused offsets ignored
        for (int a = 1; a < 16; a++) begin
            if (a != 5) wr(4'(a), 8'hA5);
        end
        rd(4'd5, r); check("R9 base after stray writes", 16'(r), 16'h01);
        rd(4'd0, r); check("R9 line after stray writes", 16'(r), 16'h00);

        // R2 R3 R5 R6 R8: every base nibble against every source
        wr(4'd0, 8'd7);
        rd(4'd0, r); check("R9 line write", 16'(r), 16'd7);
        for (int nib = 0; nib < 16; nib++) begin
            wr(4'd5, {4'(nib), 4'h1});
            for (int k = 0; k < 4; k++) begin
                vs();
                fire(4'(1 << k), 8'd7);
                check("R6 int after request", 16'(int_n), 16'h0);
                do_ack(v, oe);
                check("R1 drive during ack", 16'(oe), 16'h1);
                check("R2 R3 vector", 16'(v), 16'({4'(nib), code_exp(k), 1'b0}));
                check("R5 R6 int released", 16'(int_n), 16'h1);
                check("R1 no drive after ack", 16'(vec_oe), 16'h0);
            end
        end

        // R4 priority over every combination
        wr(4'd5, 8'h90);
        for (int m = 1; m < 16; m++) begin
            vs();
            fire(4'(m), 8'd7);
            for (int k = 3; k >= 0; k--) begin
                if (m[k]) begin
                    check("R6 int pending", 16'(int_n), 16'h0);
                    do_ack(v, oe);
                    check("R4 priority order", 16'(v), 16'({4'h9, code_exp(k), 1'b0}));
                end
            end
            check("R5 all cleared", 16'(int_n), 16'h1);
        end

        // R3 acknowledge with nothing pending
        do_ack(v, oe);
        check("R3 empty ack code", 16'(v), 16'h9E);

        // R8 line register zero disables match
        wr(4'd0, 8'd0);
        vs();
        hs(8'd0);
        check("R8 zero disables", 16'(int_n), 16'h1);
        // R8 non-matching line
        wr(4'd0, 8'd40);
        vs();
        hs(8'd41);
        check("R8 mismatch no request", 16'(int_n), 16'h1);
        wr(4'd0, 8'd0);

        // R7 periodic count
        vs();
        for (int c = 1; c <= 52; c++) begin
            hs(8'd200);
            check("R7 period", 16'(int_n), (c == 52) ? 16'h0 : 16'h1);
        end
        do_ack(v, oe);
        check("R7 raster code", 16'(v), 16'h98);
        for (int c = 1; c <= 52; c++) begin
            hs(8'd200);
            check("R7 second period", 16'(int_n), (c == 52) ? 16'h0 : 16'h1);
        end
        do_ack(v, oe);
        // R7 vsync mid-period restarts count
        for (int c = 1; c <= 30; c++) hs(8'd200);
        vs();
        for (int c = 1; c <= 52; c++) begin
            hs(8'd200);
            check("R7 after vsync", 16'(int_n), (c == 52) ? 16'h0 : 16'h1);
        end
        do_ack(v, oe);
        check("R7 cleared", 16'(int_n), 16'h1);

        // R10 request for same source during its acknowledge stays pending
        fire(4'b0001, 8'd200);
        m1_n = 1'b0; iorq_n = 1'b0; dma_req = 3'b001;
        tick();
        dma_req = '0;
        check("R10 vector dma0", 16'(vec_data), 16'h90);
        m1_n = 1'b1; iorq_n = 1'b1;
        tick();
        check("R10 still pending", 16'(int_n), 16'h0);
        do_ack(v, oe);
        check("R10 second vector", 16'(v), 16'h90);
        check("R10 cleared", 16'(int_n), 16'h1);

        // R1 vector held while base changes during a long acknowledge
        fire(4'b0100, 8'd200);
        m1_n = 1'b0; iorq_n = 1'b0;
        tick();
        check("R1 captured", 16'(vec_data), 16'h96);
        reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 8'h30;
        tick();
        reg_we = 1'b0;
        tick();
        check("R1 held", 16'(vec_data), 16'h96);
        m1_n = 1'b1; iorq_n = 1'b1;
        tick();
        check("R1 released", 16'(vec_oe), 16'h0);

        // R1 M1 alone is not an acknowledge
        fire(4'b0010, 8'd200);
        m1_n = 1'b0;
        tick();
        check("R1 m1 alone", 16'(vec_oe), 16'h0);
        m1_n = 1'b1;
        tick();
        check("R5 no clear without ack", 16'(int_n), 16'h0);
        do_ack(v, oe);
        check("R2 new base", 16'(v), 16'h32);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule